// File: doc/BRIEF.md
# SMI Entry and Resume Sequencer

This block moves a processor core into and out of system management mode. A management interrupt starts the entry. The sequencer raises an SMRAM-enable status line and holds it for a full cycle before it touches memory. It then snapshots a parameterised set of context words and pushes them into SMRAM through a single valid/ready memory port. The pushes move from a base-relative top slot toward lower addresses. After the last push it sets the handler-mode flag and redirects the program counter to the base plus a fixed handler offset. It can also raise a one-cycle cache flush request when SMRAM overlays ordinary RAM.

A resume strobe given while the handler runs reads the same slots back in the same order. The sequencer then presents the restored words and the saved program counter to the core for one cycle, and drops both the status line and the mode flag on the following cycle. The SMRAM base is programmable and survives a soft reset. A further interrupt that arrives during management mode is remembered and is taken only after the resume has finished.

Top module: `smm_seq`

## Requirements
- R1: After the hard reset `rst_n` low, `smiact`, `mode`, `mem_valid`, `pc_load`, `ctx_load` and `flush_req` are 0, and the SMRAM base equals `BASE_RST` (0x0003_0000 by default).
- R2: `smiact` rises in the cycle after an interrupt is accepted while idle, at least one full cycle before the first `mem_valid`. It stays high through save, handler and restore, and `mem_valid` is never high while `smiact` is low.
- R3: Word i of `ctx_in` (bits i*DW upward), sampled in the cycle the interrupt is accepted, is written with `mem_we`=1 to address base + 0xFFFC − 4·i, in the order i = 0, 1, … NREG−1.
- R4: While `mem_valid` is high and `mem_ready` low, `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` hold steady. A word advances only on a cycle with `mem_ready` high.
- R5: In the cycle after the last save is accepted, `mode` goes high and `pc_load` pulses for one cycle with `pc_val` = base + 0x8000.
- R6: A one-cycle `rsm` while the handler runs reads the same addresses in the same order with `mem_we`=0. After the last read it pulses `ctx_load` and `pc_load` for one cycle, with `ctx_out` holding the read words and `pc_val` equal to restored word 0, while `smiact` is still high. `smiact` and `mode` fall in the next cycle.
- R7: When `overlay` is 1 at acceptance, `flush_req` is high for exactly the first cycle of `smiact`. When `overlay` is 0, `flush_req` stays 0.
- R8: A `smi_req` seen at any time after acceptance is latched. A new entry starts (`smiact` high again) in the second cycle after the restore cycle, with no further request.
- R9: `rsm` outside the handler phase has no effect: `smiact`, `mode` and `mem_valid` stay as they were.
- R10: `base_wr` loads `base_wdata` as the new base only while idle or while the handler runs, and is ignored during save or restore. The soft reset `srst` returns the block to idle with `smiact`, `mode` and any pending request cleared, and the base unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| srst | input | 1 | Synchronous soft reset, keeps the base |
| smi_req | input | 1 | Management interrupt request |
| rsm | input | 1 | Resume strobe from the handler |
| overlay | input | 1 | SMRAM shares addresses with system RAM |
| base_wr | input | 1 | Base register write strobe |
| base_wdata | input | AW | New base value |
| ctx_in | input | NREG*DW | Live context words from the core |
| mem_valid | output | 1 | SMRAM access request |
| mem_we | output | 1 | 1 = write (save), 0 = read (restore) |
| mem_addr | output | AW | SMRAM byte address |
| mem_wdata | output | DW | Save data |
| mem_ready | input | 1 | SMRAM accepts the current access |
| mem_rdata | input | DW | Restore data, valid with mem_ready |
| smiact | output | 1 | SMRAM-enable status |
| mode | output | 1 | Pseudo-real handler environment flag |
| flush_req | output | 1 | Cache flush request pulse |
| pc_load | output | 1 | Program counter redirect strobe |
| pc_val | output | AW | Program counter target |
| ctx_load | output | 1 | Restored context strobe |
| ctx_out | output | NREG*DW | Restored context words |

## Verification
A wrong phase shows up within one cycle as a `smiact`, `mode` or `mem_valid` value that the bench's own cycle model does not predict. A wrong slot index or base shows up on `mem_addr` at the first access it affects. A lost pending request or a swapped restore word becomes visible at the ports only later: the request when `smiact` fails to come back two cycles after the restore cycle, and the word on `ctx_out` in the single restore cycle. The bench therefore compares every output in every cycle and also inspects the SMRAM image it holds.

// File: rtl/smm_seq_pkg.sv
`timescale 1ns/1ps
package smm_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACT,
        ST_SAVE,
        ST_ENTER,
        ST_HND,
        ST_REST,
        ST_EXIT
    } smm_st_e;
endpackage

// File: rtl/smm_addr_gen.sv
`timescale 1ns/1ps
// Slot and handler address arithmetic relative to the SMRAM base.
module smm_addr_gen #(
    parameter int AW = 32,
    parameter int IW = 2,
    parameter int STEP = 4,
    parameter logic [AW-1:0] TOP_OFS = 'hFFFC,
    parameter logic [AW-1:0] HDL_OFS = 'h8000
) (
    input  logic [AW-1:0] base,
    input  logic [IW-1:0] idx,
    output logic [AW-1:0] slot_addr,
    output logic [AW-1:0] hdl_addr
);
    localparam logic [AW-1:0] STEP_W = AW'(STEP);

    assign slot_addr = base + TOP_OFS - (AW'(idx) * STEP_W);
    assign hdl_addr  = base + HDL_OFS;
endmodule

// File: rtl/smm_ctx_buf.sv
`timescale 1ns/1ps
// Context snapshot / restore buffer, one register per word.
module smm_ctx_buf #(
    parameter int NREG = 4,
    parameter int DW = 32,
    parameter int IW = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap,
    input  logic [NREG*DW-1:0] cap_data,
    input  logic               wr,
    input  logic [IW-1:0]      widx,
    input  logic [DW-1:0]      wdata,
    input  logic [IW-1:0]      ridx,
    output logic [DW-1:0]      rdata,
    output logic [NREG*DW-1:0] words
);
    logic [DW-1:0] word_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[g] <= '0;
            end else if (cap) begin
                word_q[g] <= cap_data[g*DW +: DW];
            end else if (wr && (widx == IW'(g))) begin
                word_q[g] <= wdata;
            end
        end
        assign words[g*DW +: DW] = word_q[g];
    end

    assign rdata = word_q[ridx];
endmodule

// File: rtl/smm_seq.sv
`timescale 1ns/1ps
module smm_seq #(
    parameter int NREG = 4,
    parameter int DW = 32,
    parameter int AW = 32,
    parameter logic [AW-1:0] BASE_RST = 'h0003_0000,
    parameter logic [AW-1:0] TOP_OFS  = 'h0000_FFFC,
    parameter logic [AW-1:0] HDL_OFS  = 'h0000_8000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               srst,
    input  logic               smi_req,
    input  logic               rsm,
    input  logic               overlay,
    input  logic               base_wr,
    input  logic [AW-1:0]      base_wdata,
    input  logic [NREG*DW-1:0] ctx_in,
    output logic               mem_valid,
    output logic               mem_we,
    output logic [AW-1:0]      mem_addr,
    output logic [DW-1:0]      mem_wdata,
    input  logic               mem_ready,
    input  logic [DW-1:0]      mem_rdata,
    output logic               smiact,
    output logic               mode,
    output logic               flush_req,
    output logic               pc_load,
    output logic [AW-1:0]      pc_val,
    output logic               ctx_load,
    output logic [NREG*DW-1:0] ctx_out
);
    import smm_seq_pkg::*;

    localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;
    localparam int STEP = DW / 8;
    localparam logic [IW-1:0] LAST = IW'(NREG - 1);

    typedef struct packed {
        smm_st_e       st;
        logic [IW-1:0] idx;
        logic [AW-1:0] base;
        logic          pend;
        logic          flush;
        logic          mode;
    } seq_t;

    localparam seq_t SEQ_RST = '{st: ST_IDLE, idx: '0, base: BASE_RST,
                                 pend: 1'b0, flush: 1'b0, mode: 1'b0};

    seq_t q, d;
    logic cap, buf_wr;
    logic [AW-1:0] slot_addr, hdl_addr;
    logic [DW-1:0] buf_word;

    smm_addr_gen #(
        .AW(AW), .IW(IW), .STEP(STEP), .TOP_OFS(TOP_OFS), .HDL_OFS(HDL_OFS)
    ) addr_i (
        .base(q.base), .idx(q.idx), .slot_addr(slot_addr), .hdl_addr(hdl_addr)
    );

    smm_ctx_buf #(.NREG(NREG), .DW(DW), .IW(IW)) buf_i (
        .clk(clk), .rst_n(rst_n), .cap(cap), .cap_data(ctx_in),
        .wr(buf_wr), .widx(q.idx), .wdata(mem_rdata),
        .ridx(q.idx), .rdata(buf_word), .words(ctx_out)
    );

    always_comb begin
        d      = q;
        cap    = 1'b0;
        buf_wr = 1'b0;
        if (srst) begin
            d.st    = ST_IDLE;
            d.idx   = '0;
            d.pend  = 1'b0;
            d.flush = 1'b0;
            d.mode  = 1'b0;
        end else begin
            if (base_wr && (q.st == ST_IDLE || q.st == ST_HND)) begin
                d.base = base_wdata;
            end
            if (q.st != ST_IDLE) begin
                d.pend = q.pend | smi_req;
            end
            unique case (q.st)
                ST_IDLE: begin
                    if (q.pend || smi_req) begin
                        d.st    = ST_ACT;
                        d.pend  = 1'b0;
                        d.flush = overlay;
                        cap     = 1'b1;
                    end
                end
                ST_ACT: begin
                    d.st  = ST_SAVE;
                    d.idx = '0;
                end
                ST_SAVE: begin
                    if (mem_ready) begin
                        if (q.idx == LAST) begin
                            d.st   = ST_ENTER;
                            d.mode = 1'b1;
                            d.idx  = '0;
                        end else begin
                            d.idx = q.idx + 1'b1;
                        end
                    end
                end
                ST_ENTER: d.st = ST_HND;
                ST_HND: begin
                    if (rsm) begin
                        d.st  = ST_REST;
                        d.idx = '0;
                    end
                end
                ST_REST: begin
                    if (mem_ready) begin
                        buf_wr = 1'b1;
                        if (q.idx == LAST) begin
                            d.st  = ST_EXIT;
                            d.idx = '0;
                        end else begin
                            d.idx = q.idx + 1'b1;
                        end
                    end
                end
                ST_EXIT: begin
                    d.st   = ST_IDLE;
                    d.mode = 1'b0;
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEQ_RST;
        else        q <= d;
    end

    assign smiact    = (q.st != ST_IDLE);
    assign mode      = q.mode;
    assign flush_req = (q.st == ST_ACT) && q.flush;
    assign mem_valid = (q.st == ST_SAVE) || (q.st == ST_REST);
    assign mem_we    = (q.st == ST_SAVE);
    assign mem_addr  = slot_addr;
    assign mem_wdata = buf_word;
    assign pc_load   = (q.st == ST_ENTER) || (q.st == ST_EXIT);
    assign pc_val    = (q.st == ST_EXIT) ? AW'(ctx_out[DW-1:0]) : hdl_addr;
    assign ctx_load  = (q.st == ST_EXIT);
endmodule

// File: rtl/smm_seq_chk.sv
`timescale 1ns/1ps
module smm_seq_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          srst,
    input logic          smiact,
    input logic          mode,
    input logic          flush_req,
    input logic          mem_valid,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ready,
    input logic          pc_load,
    input logic          ctx_load
);
    AST_NO_ACCESS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !smiact |-> !mem_valid); // R2

    AST_STATUS_LEADS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> $past(smiact)); // R2

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n || srst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_we) && $stable(mem_addr))); // R4

    AST_ENTRY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && !ctx_load) |-> (mode && smiact)); // R5

    AST_RELEASE_AFTER_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_load && !srst) |=> (!smiact && !mode)); // R6

    AST_RESTORE_UNDER_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_load |-> smiact); // R6

    AST_FLUSH_FIRST_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> (smiact && !$past(smiact))); // R7
endmodule

bind smm_seq smm_seq_chk #(.AW(AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .srst(srst), .smiact(smiact), .mode(mode),
    .flush_req(flush_req), .mem_valid(mem_valid), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_ready(mem_ready), .pc_load(pc_load),
    .ctx_load(ctx_load)
);

// File: tb/smm_seq_tb.sv
`timescale 1ns/1ps
module smm_seq_tb_top;
    localparam int NREG = 4;
    localparam int DW = 32;
    localparam int AW = 32;
    localparam logic [31:0] BASE0 = 32'h0003_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0, srst = 1'b0, smi_req = 1'b0, rsm = 1'b0, overlay = 1'b0;
    logic base_wr = 1'b0;
    logic [AW-1:0] base_wdata = '0;
    logic [NREG*DW-1:0] ctx_in = '0;
    logic mem_valid, mem_we, mem_ready = 1'b1;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata = '0;
    logic smiact, mode, flush_req, pc_load, ctx_load;
    logic [AW-1:0] pc_val;
    logic [NREG*DW-1:0] ctx_out;

    always #2 clk = ~clk;

    smm_seq dut_i (
        .clk(clk), .rst_n(rst_n), .srst(srst), .smi_req(smi_req), .rsm(rsm),
        .overlay(overlay), .base_wr(base_wr), .base_wdata(base_wdata),
        .ctx_in(ctx_in), .mem_valid(mem_valid), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .smiact(smiact), .mode(mode),
        .flush_req(flush_req), .pc_load(pc_load), .pc_val(pc_val),
        .ctx_load(ctx_load), .ctx_out(ctx_out)
    );

    int n_chk = 0, n_fail = 0, cyc = 0, rdy_mode = 0, rdy_cnt = 0;
    logic [31:0] mem [logic [31:0]];

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // reference model state
    int ph = 0, mi = 0;
    logic [31:0] mbase = BASE0;
    logic mpend = 0, mflush = 0, mmode = 0;
    logic [31:0] mbuf [NREG];

    always @(posedge clk) begin
        int p;
        p = ph;
        cyc++;
        if (rst_n && mem_valid && mem_we && mem_ready) mem[mem_addr] = mem_wdata;
        if (!rst_n) begin
            ph = 0; mi = 0; mbase = BASE0; mpend = 0; mflush = 0; mmode = 0;
            for (int i = 0; i < NREG; i++) mbuf[i] = '0;
        end else if (srst) begin
            ph = 0; mi = 0; mpend = 0; mflush = 0; mmode = 0;
        end else begin
            if (base_wr && (p == 0 || p == 4)) mbase = base_wdata;
            if (p != 0) mpend = mpend | smi_req;
            case (p)
                0: if (mpend || smi_req) begin
                    ph = 1; mpend = 0; mflush = overlay;
                    for (int i = 0; i < NREG; i++) mbuf[i] = ctx_in[i*DW +: DW];
                end
                1: begin ph = 2; mi = 0; end
                2: if (mem_ready) begin
                    if (mi == NREG - 1) begin ph = 3; mmode = 1; mi = 0; end
                    else mi++;
                end
                3: ph = 4;
                4: if (rsm) begin ph = 5; mi = 0; end
                5: if (mem_ready) begin
                    mbuf[mi] = mem_rdata;
                    if (mi == NREG - 1) begin ph = 6; mi = 0; end
                    else mi++;
                end
                default: begin ph = 0; mmode = 0; end
            endcase
        end
    end

    always @(posedge clk) begin
        #1;
        rdy_cnt++;
        mem_ready = (rdy_mode == 0) ? 1'b1 : (rdy_cnt % 3 == 0);
    end

    always @(negedge clk) begin
        if (rst_n) begin
            logic [31:0] ea;
            ea = mbase + 32'hFFFC - 32'(4 * mi);
            chk("R2 smiact", smiact, ph != 0);
            chk("R5 mode", mode, mmode);
            chk("R7 flush_req", flush_req, ph == 1 && mflush);
            chk("R4 mem_valid", mem_valid, ph == 2 || ph == 5);
            chk("R6 ctx_load", ctx_load, ph == 6);
            chk("R5 pc_load", pc_load, ph == 3 || ph == 6);
            if (ph == 2 || ph == 5) begin
                chk("R3 mem_addr", mem_addr, ea);
                chk("R3 mem_we", mem_we, ph == 2);
                if (ph == 2) chk("R3 mem_wdata", mem_wdata, mbuf[mi]);
            end
            if (ph == 3) chk("R5 pc_val", pc_val, mbase + 32'h8000);
            if (ph == 6) begin
                chk("R6 pc_val", pc_val, mbuf[0]);
                for (int i = 0; i < NREG; i++) chk("R6 ctx_out", ctx_out[i*DW +: DW], mbuf[i]);
            end
        end
        mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
    end

    always @(posedge clk) begin
        if (cyc > 20000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic wait_pc();
        while (!pc_load) tick();
    endtask

    task automatic wait_restore();
        while (!ctx_load) tick();
    endtask

    initial begin
        ctx_in = {32'hD0D0_0003, 32'hC0C0_0002, 32'hB0B0_0001, 32'hA0A0_0000};
        repeat (3) tick();
        chk("R1 smiact reset", smiact, 0);
        chk("R1 mode reset", mode, 0);
        chk("R1 mem_valid reset", mem_valid, 0);
        chk("R1 flush reset", flush_req, 0);
        rst_n = 1'b1;
        tick();

        // first entry, default base, always ready
        smi_req = 1'b1; tick(); smi_req = 1'b0;
        chk("R2 smiact rises", smiact, 1);
        chk("R2 no access yet", mem_valid, 0);
        chk("R7 no flush without overlay", flush_req, 0);
        wait_pc();
        chk("R1 R5 handler at reset base", pc_val, BASE0 + 32'h8000);
        for (int i = 0; i < NREG; i++)
            chk("R3 saved word", mem[BASE0 + 32'hFFFC - 32'(4 * i)], ctx_in[i*DW +: DW]);
        tick();
        for (int i = 0; i < NREG; i++)
            mem[BASE0 + 32'hFFFC - 32'(4 * i)] = 32'h5500_0000 + 32'(i);
        rsm = 1'b1; tick(); rsm = 1'b0;
        wait_restore();
        chk("R6 restored word 2", ctx_out[2*DW +: DW], 32'h5500_0002);
        chk("R6 restored pc", pc_val, 32'h5500_0000);
        chk("R6 status held in restore cycle", smiact, 1);
        tick();
        chk("R6 status released", smiact, 0);

        // resume strobe while idle
        rsm = 1'b1; tick(); rsm = 1'b0;
        repeat (3) tick();
        chk("R9 rsm idle smiact", smiact, 0);
        chk("R9 rsm idle mem_valid", mem_valid, 0);

        // new base, overlay, stalling memory, pending SMI
        base_wr = 1'b1; base_wdata = 32'h000A_0000; tick(); base_wr = 1'b0;
        overlay = 1'b1; rdy_mode = 1;
        ctx_in = {32'h1111_0003, 32'h1111_0002, 32'h1111_0001, 32'h1111_0000};
        smi_req = 1'b1; tick(); smi_req = 1'b0;
        chk("R7 flush pulse", flush_req, 1);
        tick();
        base_wr = 1'b1; base_wdata = 32'h1234_0000; tick(); base_wr = 1'b0;
        wait_pc();
        chk("R10 base programmed, save-time write ignored", pc_val, 32'h000A_8000);
        chk("R3 saved at new base", mem[32'h000A_FFFC], 32'h1111_0000);
        tick();
        smi_req = 1'b1; tick(); smi_req = 1'b0;
        chk("R8 no service inside handler", mem_valid, 0);
        rsm = 1'b1; tick(); rsm = 1'b0;
        wait_restore();
        tick();
        chk("R8 released before re-entry", smiact, 0);
        tick();
        chk("R8 pending request re-enters", smiact, 1);
        wait_pc(); tick();
        rsm = 1'b1; tick(); rsm = 1'b0;
        wait_restore(); tick();

        // soft reset in the handler
        overlay = 1'b0; rdy_mode = 0;
        smi_req = 1'b1; tick(); smi_req = 1'b0;
        wait_pc(); tick();
        srst = 1'b1; tick(); srst = 1'b0;
        chk("R10 srst clears smiact", smiact, 0);
        chk("R10 srst clears mode", mode, 0);
        smi_req = 1'b1; tick(); smi_req = 1'b0;
        wait_pc();
        chk("R10 base kept over srst", pc_val, 32'h000A_8000);
        tick();
        srst = 1'b1; tick(); srst = 1'b0;
        repeat (2) tick();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule